// File: doc/BRIEF.md
# Prescaled Interval Timer

A single-channel down-counting timer with a small register bus. Software loads a start value into the live count register, picks a power-of-two clock division, and arms the channel through a control register. Each prescaled tick lowers the count by one. When a tick takes the count from one to zero, the channel raises a sticky pending flag. An interrupt line presents that flag when the interrupt enable bit allows it.

The channel runs in one of two modes. In the repeating mode the count is refilled from an interval register each time it expires, so events recur at a fixed period. In the single-shot mode the channel stops after one expiry by clearing its own run bit. Software clears the pending flag by writing a one to it. It can also overwrite the live count at any time to set the delay of the next event.

Top module: `ivt_timer`

## Requirements
- R1: After a synchronous reset every register reads zero and `irq` is low.
- R2: Register offsets are: interrupt enable at 0x00 (bit 0), pending status at 0x04 (bit 0), control at 0x10 (bits 7:0), interval at 0x14, and live count at 0x18. Any other offset reads zero. Unused bits of the control, enable and status registers read zero.
- R3: Control bits [6:4] hold a division code n. The channel ticks once every 2^n clock cycles. The first tick lands 2^n cycles after the write that arms the channel.
- R4: Each tick lowers the count by one. A tick that takes the count from 1 to 0 is an expiry and sets the pending status on that same edge. A start value of C therefore expires C·2^n cycles after arming.
- R5: The repeating mode is selected by control bit 1 = 1 with bit 7 = 0. On expiry in this mode the count is loaded from the interval register and counting continues.
- R6: The single-shot mode is selected by control bit 7 = 1, and it takes precedence over bit 1. On expiry in this mode the count becomes 0 and hardware clears run bit 0.
- R7: `irq` equals pending status AND interrupt-enable bit 0. It therefore stays high until software clears the status.
- R8: Writing 1 to status bit 0 clears the pending flag. Writing 0 has no effect. If an expiry and a clear fall on the same cycle, the flag stays set.
- R9: Clearing run bit 0 freezes the count and resets the prescaler. After the channel is re-armed, the next tick comes a full 2^n cycles later.
- R10: Ticks occur only while control bits [3:2] equal 1, which selects the main clock input. Any other source code leaves the count unchanged.
- R11: A write to the count register takes effect on the next cycle and overrides a tick on that same cycle. Reads return the live count.
- R12: A tick that finds the count already at zero never sets the status. In the repeating mode it loads the interval. In any other mode it leaves the count at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock, also the counting source |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A table of start values against division codes 0 to 7 measures the cycles to expiry. Because each row pairs a different count with a different code, an off-by-one in either the divider or the down-counter shows up as a wrong cycle total.

Separate directed runs test the following:
- The repeating mode, where the reload value and the second period expose a missing or late refill.
- The single-shot mode with the reload bit also set, which tells mode precedence apart.
- A pause and resume with code 2, which separates a divider that restarts from one that keeps its phase.
- A zero start value, a mid-run count overwrite, a foreign source code and the status clear rules.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int PRE_W = 3;

    localparam logic [7:0] OFF_IE   = 8'h00;
    localparam logic [7:0] OFF_STAT = 8'h04;
    localparam logic [7:0] OFF_CTRL = 8'h10;
    localparam logic [7:0] OFF_INTV = 8'h14;
    localparam logic [7:0] OFF_CNT  = 8'h18;

    localparam logic [1:0] SRC_MAIN = 2'd1;

    // Field layout matches the control register bit positions.
    typedef struct packed {
        logic             single;
        logic [PRE_W-1:0] div_code;
        logic [1:0]       src;
        logic             repeat_en;
        logic             run;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_IE,
        SEL_STAT,
        SEL_CTRL,
        SEL_INTV,
        SEL_CNT,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [7:0] off);
        case (off)
            OFF_IE:   return SEL_IE;
            OFF_STAT: return SEL_STAT;
            OFF_CTRL: return SEL_CTRL;
            OFF_INTV: return SEL_INTV;
            OFF_CNT:  return SEL_CNT;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic repeats(input ctrl_t c);
        return c.repeat_en && !c.single;
    endfunction

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
    parameter int CODE_W = ivt_pkg::PRE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int DIV_W = (1 << CODE_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;

    // limit = 2^code - 1, built as a thermometer mask
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            limit[i] = (i < int'(code));
        end
    end

    assign tick = active && (div_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    AST_DIV_RESTART: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> (div_q == '0)); // R9

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] interval,
    input  logic             periodic,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_d;
    logic             at_zero;

    assign at_zero = (count == '0);
    assign expire  = tick && !load && (count == ONE);

    always_comb begin
        count_d = count;
        if (load) begin
            count_d = load_val;
        end else if (tick) begin
            if (count == ONE) begin
                count_d = periodic ? interval : '0;
            end else if (at_zero) begin
                count_d = periodic ? interval : '0;
            end else begin
                count_d = count - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            count <= count_d;
        end
    end

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && count > ONE) |=> (count == $past(count) - ONE)); // R4

    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (expire && periodic) |=> (count == $past(interval))); // R5

    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count)); // R9

    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && at_zero && !periodic) |=> (count == '0)); // R12

    AST_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val))); // R11

endmodule

// File: rtl/ivt_status.sv
module ivt_status (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic enable,
    output logic pending,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (set) begin
            pending <= 1'b1;
        end else if (clr) begin
            pending <= 1'b0;
        end
    end

    assign irq = pending && enable;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set |=> pending); // R8

    AST_W1C: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !pending); // R8

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pending && !clr) |=> pending); // R7

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    import ivt_pkg::*;

    localparam int CTRL_W = $bits(ctrl_t);

    reg_sel_e         sel;
    ctrl_t            ctrl_q;
    logic             ie_q;
    logic [CNT_W-1:0] interval_q;
    logic [CNT_W-1:0] count;
    logic             tick;
    logic             expire;
    logic             pending;
    logic             src_ok;
    logic             active;
    logic             wr_ie, wr_stat, wr_ctrl, wr_intv, wr_cnt;

    assign sel     = decode_offset(8'(bus_addr));
    assign wr_ie   = bus_we && (sel == SEL_IE);
    assign wr_stat = bus_we && (sel == SEL_STAT);
    assign wr_ctrl = bus_we && (sel == SEL_CTRL);
    assign wr_intv = bus_we && (sel == SEL_INTV);
    assign wr_cnt  = bus_we && (sel == SEL_CNT);

    assign src_ok = (ctrl_q.src == SRC_MAIN);
    assign active = ctrl_q.run && src_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            ie_q       <= 1'b0;
            interval_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            end else if (expire && ctrl_q.single) begin
                ctrl_q.run <= 1'b0;
            end
            if (wr_ie) begin
                ie_q <= bus_wdata[0];
            end
            if (wr_intv) begin
                interval_q <= CNT_W'(bus_wdata);
            end
        end
    end

    ivt_prescaler #(.CODE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .code   (ctrl_q.div_code),
        .tick   (tick)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (wr_cnt),
        .load_val (CNT_W'(bus_wdata)),
        .interval (interval_q),
        .periodic (repeats(ctrl_q)),
        .count    (count),
        .expire   (expire)
    );

    ivt_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .set     (expire),
        .clr     (wr_stat && bus_wdata[0]),
        .enable  (ie_q),
        .pending (pending),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_IE:   bus_rdata[0] = ie_q;
            SEL_STAT: bus_rdata[0] = pending;
            SEL_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
            SEL_INTV: bus_rdata = DATA_W'(interval_q);
            SEL_CNT:  bus_rdata = DATA_W'(count);
            default:  bus_rdata = '0;
        endcase
    end

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl_q.single && !wr_ctrl) |=> !ctrl_q.run); // R6

    AST_NO_TICK_OFF_SRC: assert property (@(posedge clk) disable iff (rst)
        (!src_ok && !wr_cnt) |=> $stable(count)); // R10

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_stat && !wr_ie) |=> irq); // R7

endmodule

// File: tb/ivt_timer_test.sv
module ivt_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    localparam logic [7:0] A_IE = 8'h00, A_ST = 8'h04, A_CT = 8'h10,
                           A_IV = 8'h14, A_CN = 8'h18;

    // division code, start value, expected cycles to expiry
    localparam int NV = 7;
    localparam int V_CODE[NV] = '{0, 0, 1, 2, 4, 7, 3};
    localparam int V_CNT [NV] = '{1, 7, 3, 5, 3, 2, 1};
    localparam int V_EXP [NV] = '{1, 7, 6, 20, 48, 256, 8};

    always #5 clk = ~clk;

    ivt_timer uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_status(output int n);
        logic [31:0] s;
        n = 0;
        s = 0;
        while (s[0] !== 1'b1 && n < 5000) begin
            @(posedge clk); #1;
            n++;
            rd(A_ST, s);
        end
    endtask

    task automatic quiesce;
        wr(A_CT, 32'h0);
        wr(A_ST, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd(A_IE, v); chk("R1 ie", v, 0);
        rd(A_ST, v); chk("R1 status", v, 0);
        rd(A_CT, v); chk("R1 ctrl", v, 0);
        rd(A_IV, v); chk("R1 interval", v, 0);
        rd(A_CN, v); chk("R1 count", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 map and unused bits
        rd(8'h08, v); chk("R2 unmapped", v, 0);
        wr(A_CT, 32'hABCD_E070);
        rd(A_CT, v); chk("R2 ctrl mask", v, 32'h70);
        wr(A_IE, 32'hFFFF_FFFE);
        rd(A_IE, v); chk("R2 ie mask", v, 0);
        wr(A_CT, 32'h0);

        // R3/R4 table of codes and start values
        for (int i = 0; i < NV; i++) begin
            quiesce();
            wr(A_CN, 32'(V_CNT[i]));
            wr(A_CT, 32'((V_CODE[i] << 4) | 5));
            wait_status(n);
            chk($sformatf("R3 R4 row%0d cycles", i), 32'(n), 32'(V_EXP[i]));
        end

        // R5 repeating mode
        quiesce();
        wr(A_IV, 32'd4);
        wr(A_CN, 32'd4);
        wr(A_CT, 32'h07);
        wait_status(n);
        chk("R5 first period", 32'(n), 4);
        rd(A_CN, v); chk("R5 reload value", v, 4);
        wr(A_ST, 32'h1);
        wait_status(n);
        chk("R5 second period", 32'(n), 3);
        rd(A_CT, v); chk("R5 still running", v & 1, 1);

        // R6 single-shot wins over reload
        quiesce();
        wr(A_IV, 32'd9);
        wr(A_CN, 32'd3);
        wr(A_CT, 32'h87);
        wait_status(n);
        chk("R6 period", 32'(n), 3);
        rd(A_CT, v); chk("R6 run cleared", v & 1, 0);
        rd(A_CN, v); chk("R6 count zero", v, 0);
        repeat (5) @(posedge clk); #1;
        rd(A_CN, v); chk("R6 count stays", v, 0);

        // R7/R8 interrupt gating and clear
        chk("R7 irq masked", {31'b0, irq}, 0);
        wr(A_IE, 32'h1);
        chk("R7 irq raised", {31'b0, irq}, 1);
        wr(A_ST, 32'h0);
        rd(A_ST, v); chk("R8 write zero ignored", v, 1);
        chk("R7 irq held", {31'b0, irq}, 1);
        wr(A_ST, 32'h1);
        rd(A_ST, v); chk("R8 cleared", v, 0);
        chk("R7 irq dropped", {31'b0, irq}, 0);
        wr(A_IE, 32'h0);

        // R9 freeze and prescaler restart
        quiesce();
        wr(A_CN, 32'd100);
        wr(A_CT, 32'h25);
        repeat (6) @(posedge clk); #1;
        rd(A_CN, v); chk("R9 running", v, 99);
        wr(A_CT, 32'h24);
        repeat (10) @(posedge clk); #1;
        rd(A_CN, v); chk("R9 frozen", v, 99);
        wr(A_CT, 32'h25);
        repeat (3) @(posedge clk); #1;
        rd(A_CN, v); chk("R9 no early tick", v, 99);
        @(posedge clk); #1;
        rd(A_CN, v); chk("R9 full period tick", v, 98);

        // R10 foreign source
        quiesce();
        wr(A_CN, 32'd5);
        wr(A_CT, 32'h09);
        repeat (20) @(posedge clk); #1;
        rd(A_CN, v); chk("R10 count unchanged", v, 5);
        rd(A_ST, v); chk("R10 no status", v, 0);

        // R11 overwrite while running
        quiesce();
        wr(A_CN, 32'd50);
        wr(A_CT, 32'h05);
        repeat (3) @(posedge clk);
        wr(A_CN, 32'd2);
        wait_status(n);
        chk("R11 new delay", 32'(n), 2);

        // R12 tick at zero in repeating mode
        quiesce();
        wr(A_IV, 32'd3);
        wr(A_CN, 32'd0);
        wr(A_CT, 32'h07);
        @(posedge clk); #1;
        rd(A_CN, v); chk("R12 reload from zero", v, 3);
        rd(A_ST, v); chk("R12 no status", v, 0);
        wait_status(n);
        chk("R12 then period", 32'(n), 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule